// File: doc/BRIEF.md
# External Bus Chip-Select and Wait Unit

This unit sits between a small 16-bit processor core and its external memory bus. It holds three byte-wide control registers that software reaches through a simple write/read port. From these registers it drives four active-low chip selects, a software wait count for every access, and the function of the upper address pins. The 1 MB external space is split into four fixed quarters, with one quarter for each chip select.

Each chip select has two control bits. An enable bit turns the pin from a general port into a chip select. A wait bit uses inverted polarity: 0 keeps a wait state and 1 drops it. A global wait override and a set of per-region force bits can both cancel a "no wait" setting. The force bits are meant for regions that use a ready handshake or the multiplexed bus. A second register gives each region a 2-bit wait-length field.

A width code chooses 12-, 16- or 20-bit addressing. The pins above the chosen width act as ports, and they are driven low on the address output. A strap input is captured once after reset and selects an 8-bit or a 16-bit data bus.

Top module: `extbus_csw_unit`

## Requirements
- R1: After reset the chip-select control register (offset 0x08) reads 0x01, the wait-length register (offset 0x09) reads 0x00 and the mode register (offset 0x0A) reads 0x00. All cs_n outputs are high, wait_cycles is 0 and cs_pin_en is 4'b0001.
- R2: A register write at offset 0x08, 0x09 or 0x0A stores the byte, and reading that offset returns it. Reading any other offset returns 0x00. A write to any other offset changes no register.
- R3: In the chip-select control register, bits 3:0 enable CS3..CS0 and bits 7:4 are the wait bits of CS3..CS0. The region is acc_addr[19:18]. When acc_req is high at a clock edge and the region's enable bit is 1, cs_n of that region is low for the following cycle and the other cs_n outputs stay high.
- R4: An access to a region whose enable bit is 0 drives no chip select and a wait count of 0. cs_pin_en always equals the four enable bits.
- R5: For an enabled region whose effective wait bit is 0, wait_cycles is the region's field in the wait-length register plus one, and is registered with cs_n. Region i uses bits 2i+1:2i of that register. An effective wait bit of 1 gives wait_cycles 0.
- R6: When mode bit 2 (global wait) is 1, every region behaves as if its wait bit were 0.
- R7: Mode bits 7:4 are per-region force bits for regions 3..0. A set bit makes that region behave as if its wait bit were 0.
- R8: Mode bits 1:0 select the address width. 2'b00 gives 20 bits, with both pin groups in address use. 2'b01 gives 16 bits, with only A12–A15 in address use. 2'b11 gives 12 bits, with neither group in address use.
- R9: A mode write whose bits 1:0 are 2'b10 keeps the previous width code. The other mode bits are still written.
- R10: ext_addr carries acc_addr for one cycle per access. Bits that lie in a pin group used as a port are driven 0.
- R11: bus_is_8bit takes the value of byte_strap in the first clock after reset and then holds, even if the strap changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| acc_req | input | 1 | External access request from the core |
| acc_addr | input | 20 | External access address |
| byte_strap | input | 1 | Data width strap, high selects 8 bits |
| cs_n | output | 4 | Active-low chip selects |
| cs_pin_en | output | 4 | Chip-select pin function per region (1 = chip select) |
| wait_cycles | output | 3 | Wait states for the current access |
| ext_addr | output | 20 | Address driven to the bus, masked to the width |
| mid_pins_addr | output | 1 | A12–A15 carry address |
| top_pins_addr | output | 1 | A16–A19 carry address |
| bus_is_8bit | output | 1 | Captured data bus width |

## Verification
A corrupted enable or wait bit appears on cs_n or wait_cycles in the cycle after the next access to that region. It can also be seen at once by reading the register back. A wrong width code changes mid_pins_addr and top_pins_addr immediately, and it shows in the masking of ext_addr on the next access. A strap that is captured again later appears as a change on bus_is_8bit when byte_strap changes after start-up.

// File: rtl/extbus_csw_pkg.sv
package extbus_csw_pkg;
    typedef enum logic [1:0] {
        AW20   = 2'b00,
        AW16   = 2'b01,
        AW_BAD = 2'b10,
        AW12   = 2'b11
    } aw_code_e;
endpackage

// File: rtl/extbus_csw_regs.sv
module extbus_csw_regs
    import extbus_csw_pkg::*;
#(
    parameter int          NCS      = 4,
    parameter int          WF_W     = 2,
    parameter int          RA_W     = 8,
    parameter logic [7:0]  CSR_OFS  = 8'h08,
    parameter logic [7:0]  WCNT_OFS = 8'h09,
    parameter logic [7:0]  MODE_OFS = 8'h0A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [RA_W-1:0]       addr,
    input  logic [2*NCS-1:0]      wdata,
    output logic [2*NCS-1:0]      rdata,
    output logic [NCS-1:0]        cs_en,
    output logic [NCS-1:0]        cs_nowait,
    output logic [NCS*WF_W-1:0]   wait_fld,
    output aw_code_e              aw_code,
    output logic                  glob_wait,
    output logic [NCS-1:0]        force_wait
);
    localparam int BYTE_W = 2 * NCS;

    typedef struct packed {
        logic [BYTE_W-1:0]   csr;
        logic [NCS*WF_W-1:0] wcnt;
        aw_code_e            aw;
        logic                gwait;
        logic [NCS-1:0]      frc;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        if (wr) begin
            case (addr)
                CSR_OFS:  regs_d.csr  = wdata;
                WCNT_OFS: regs_d.wcnt = wdata[NCS*WF_W-1:0];
                MODE_OFS: begin
                    regs_d.gwait = wdata[2];
                    regs_d.frc   = wdata[BYTE_W-1 -: NCS];
                    if (wdata[1:0] != AW_BAD)
                        regs_d.aw = aw_code_e'(wdata[1:0]);
                end
                default: ;
            endcase
        end
        if (rd) begin
            case (addr)
                CSR_OFS:  rdata = regs_q.csr;
                WCNT_OFS: rdata = BYTE_W'(regs_q.wcnt);
                MODE_OFS: rdata = {regs_q.frc, 1'b0, regs_q.gwait, regs_q.aw};
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.csr   <= BYTE_W'(1);
            regs_q.wcnt  <= '0;
            regs_q.aw    <= AW20;
            regs_q.gwait <= 1'b0;
            regs_q.frc   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cs_en      = regs_q.csr[NCS-1:0];
    assign cs_nowait  = regs_q.csr[BYTE_W-1 -: NCS];
    assign wait_fld   = regs_q.wcnt;
    assign aw_code    = regs_q.aw;
    assign glob_wait  = regs_q.gwait;
    assign force_wait = regs_q.frc;

    // R9: the illegal width code never reaches the register
    a_r9_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.aw != AW_BAD);

    // R9: a write carrying the illegal code leaves the width as it was
    a_r9_bad_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == MODE_OFS && wdata[1:0] == 2'b10) |=> $stable(regs_q.aw));
endmodule

// File: rtl/extbus_csw_decode.sv
module extbus_csw_decode
    import extbus_csw_pkg::*;
#(
    parameter int AW     = 20,
    parameter int NCS    = 4,
    parameter int WF_W   = 2,
    parameter int MID_LO = 12,
    parameter int TOP_LO = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_req,
    input  logic [AW-1:0]         acc_addr,
    input  logic [NCS-1:0]        cs_en,
    input  logic [NCS-1:0]        cs_nowait,
    input  logic [NCS*WF_W-1:0]   wait_fld,
    input  logic                  glob_wait,
    input  logic [NCS-1:0]        force_wait,
    input  logic                  mid_addr,
    input  logic                  top_addr,
    output logic [NCS-1:0]        cs_n,
    output logic [WF_W:0]         wait_cycles,
    output logic [AW-1:0]         ext_addr
);
    localparam int RSEL_W = $clog2(NCS);
    localparam int WC_W   = WF_W + 1;

    typedef struct packed {
        logic [NCS-1:0]  cs_n;
        logic [WC_W-1:0] wcyc;
        logic [AW-1:0]   addr;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [AW-1:0]     keep_mask;
    logic [RSEL_W-1:0] sel;
    logic              eff_nowait;

    for (genvar b = 0; b < AW; b++) begin : g_mask
        if (b < MID_LO) begin : g_low
            assign keep_mask[b] = 1'b1;
        end else if (b < TOP_LO) begin : g_mid
            assign keep_mask[b] = mid_addr;
        end else begin : g_top
            assign keep_mask[b] = top_addr;
        end
    end

    always_comb begin
        acc_d      = '0;
        acc_d.cs_n = '1;
        sel        = acc_addr[AW-1 -: RSEL_W];
        eff_nowait = cs_nowait[sel] & ~glob_wait & ~force_wait[sel];
        if (acc_req) begin
            acc_d.addr = acc_addr & keep_mask;
            if (cs_en[sel]) begin
                acc_d.cs_n[sel] = 1'b0;
                if (!eff_nowait)
                    acc_d.wcyc = WC_W'(wait_fld[sel*WF_W +: WF_W]) + WC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.cs_n <= '1;
            acc_q.wcyc <= '0;
            acc_q.addr <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cs_n        = acc_q.cs_n;
    assign wait_cycles = acc_q.wcyc;
    assign ext_addr    = acc_q.addr;

    // R3: at most one chip select active
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3: a chip select only follows a request
    a_r3_cs_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (~&cs_n) |-> $past(acc_req));

    // R4/R5: a wait count only comes with an active chip select
    a_r5_wait_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cycles != '0) |-> (~&cs_n));

    // R6: with the global override, an enabled access always waits
    a_r6_global_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && glob_wait && cs_en[sel]) |=> (wait_cycles != '0));
endmodule

// File: rtl/extbus_csw_unit.sv
module extbus_csw_unit
    import extbus_csw_pkg::*;
#(
    parameter int AW   = 20,
    parameter int NCS  = 4,
    parameter int WF_W = 2,
    parameter int RA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              acc_req,
    input  logic [AW-1:0]     acc_addr,
    input  logic              byte_strap,
    output logic [NCS-1:0]    cs_n,
    output logic [NCS-1:0]    cs_pin_en,
    output logic [WF_W:0]     wait_cycles,
    output logic [AW-1:0]     ext_addr,
    output logic              mid_pins_addr,
    output logic              top_pins_addr,
    output logic              bus_is_8bit
);
    logic [NCS-1:0]      cs_nowait, force_wait;
    logic [NCS*WF_W-1:0] wait_fld;
    logic                glob_wait;
    aw_code_e            aw_code;

    typedef struct packed {
        logic done;
        logic byte8;
    } strap_t;

    strap_t strap_d, strap_q;

    extbus_csw_regs #(.NCS(NCS), .WF_W(WF_W), .RA_W(RA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .cs_en      (cs_pin_en),
        .cs_nowait  (cs_nowait),
        .wait_fld   (wait_fld),
        .aw_code    (aw_code),
        .glob_wait  (glob_wait),
        .force_wait (force_wait)
    );

    assign mid_pins_addr = (aw_code != AW12);
    assign top_pins_addr = (aw_code == AW20);

    extbus_csw_decode #(.AW(AW), .NCS(NCS), .WF_W(WF_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_req     (acc_req),
        .acc_addr    (acc_addr),
        .cs_en       (cs_pin_en),
        .cs_nowait   (cs_nowait),
        .wait_fld    (wait_fld),
        .glob_wait   (glob_wait),
        .force_wait  (force_wait),
        .mid_addr    (mid_pins_addr),
        .top_addr    (top_pins_addr),
        .cs_n        (cs_n),
        .wait_cycles (wait_cycles),
        .ext_addr    (ext_addr)
    );

    always_comb begin
        strap_d = strap_q;
        if (!strap_q.done) begin
            strap_d.done  = 1'b1;
            strap_d.byte8 = byte_strap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_q <= '0;
        else        strap_q <= strap_d;
    end

    assign bus_is_8bit = strap_q.byte8;

    // R11: once captured, the width never moves
    a_r11_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q.done |=> $stable(bus_is_8bit));

    // R10: bits of a port group are never driven as address
    a_r10_top_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_pins_addr && $stable(aw_code)) |-> (ext_addr[AW-1:16] == '0));
endmodule

// File: tb/extbus_csw_unit_test.sv
module extbus_csw_unit_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic        acc_req = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        byte_strap = 1'b1;
    logic [3:0]  cs_n, cs_pin_en;
    logic [2:0]  wait_cycles;
    logic [19:0] ext_addr;
    logic        mid_pins_addr, top_pins_addr, bus_is_8bit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    extbus_csw_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_req(acc_req), .acc_addr(acc_addr), .byte_strap(byte_strap),
        .cs_n(cs_n), .cs_pin_en(cs_pin_en), .wait_cycles(wait_cycles),
        .ext_addr(ext_addr), .mid_pins_addr(mid_pins_addr),
        .top_pins_addr(top_pins_addr), .bus_is_8bit(bus_is_8bit)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // one access; result sampled at the negedge after the registering edge
    task automatic do_acc(logic [19:0] a, output logic [3:0] c,
                          output logic [2:0] w, output logic [19:0] ea);
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a;
        @(negedge clk);
        c = cs_n; w = wait_cycles; ea = ext_addr;
        acc_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 cs_n", cs_n, 4'hF);
        check("R1 wait", wait_cycles, 0);
        check("R1 pin_en", cs_pin_en, 4'b0001);
        rd_reg(8'h08, d); check("R1 csr", d, 8'h01);
        rd_reg(8'h09, d); check("R1 wcnt", d, 8'h00);
        rd_reg(8'h0A, d); check("R1 mode", d, 8'h00);
        check("R8 reset mid", mid_pins_addr, 1);
        check("R8 reset top", top_pins_addr, 1);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr_reg(8'h09, 8'hE4);
        rd_reg(8'h09, d); check("R2 wcnt rw", d, 8'hE4);
        wr_reg(8'h05, 8'hFF);
        rd_reg(8'h05, d); check("R2 unused read", d, 8'h00);
        rd_reg(8'h08, d); check("R2 csr untouched", d, 8'h01);
        rd_reg(8'h0A, d); check("R2 mode untouched", d, 8'h00);
    endtask

    task automatic t_cs_basic();
        logic [3:0] c; logic [2:0] w; logic [19:0] ea;
        do_acc(20'h01234, c, w, ea);
        check("R3 cs region0", c, 4'b1110);
        check("R5 wait region0", w, 1);
        @(negedge clk);
        check("R3 cs one cycle", cs_n, 4'hF);
        do_acc(20'h45678, c, w, ea);
        check("R4 disabled cs", c, 4'hF);
        check("R4 disabled wait", w, 0);
        wr_reg(8'h08, 8'h0F);
        check("R4 pin_en", cs_pin_en, 4'hF);
        do_acc(20'hC0000, c, w, ea);
        check("R3 cs region3", c, 4'b0111);
        check("R5 wait region3", w, 4);
        do_acc(20'h80010, c, w, ea);
        check("R5 wait region2", w, 3);
    endtask

    task automatic t_nowait();
        logic [3:0] c; logic [2:0] w; logic [19:0] ea;
        wr_reg(8'h08, 8'hAF);
        do_acc(20'h40000, c, w, ea);
        check("R3 cs region1", c, 4'b1101);
        check("R5 nowait region1", w, 0);
        do_acc(20'h00000, c, w, ea);
        check("R5 wait region0 kept", w, 1);
        wr_reg(8'h0A, 8'h04);
        do_acc(20'h40000, c, w, ea);
        check("R6 global region1", w, 2);
        do_acc(20'hC0000, c, w, ea);
        check("R6 global region3", w, 4);
        wr_reg(8'h0A, 8'h80);
        do_acc(20'hC0000, c, w, ea);
        check("R7 force region3", w, 4);
        do_acc(20'h40000, c, w, ea);
        check("R7 unforced region1", w, 0);
    endtask

    task automatic t_width();
        logic [3:0] c; logic [2:0] w; logic [19:0] ea; logic [7:0] d;
        wr_reg(8'h0A, 8'h01);
        check("R8 16b mid", mid_pins_addr, 1);
        check("R8 16b top", top_pins_addr, 0);
        do_acc(20'hFABCD, c, w, ea);
        check("R10 16b addr", ea, 20'h0ABCD);
        wr_reg(8'h0A, 8'h03);
        check("R8 12b mid", mid_pins_addr, 0);
        check("R8 12b top", top_pins_addr, 0);
        do_acc(20'hFABCD, c, w, ea);
        check("R10 12b addr", ea, 20'h00BCD);
        wr_reg(8'h0A, 8'h06);
        rd_reg(8'h0A, d); check("R9 bad code kept", d, 8'h07);
        check("R9 pins kept", {mid_pins_addr, top_pins_addr}, 2'b00);
        wr_reg(8'h0A, 8'h00);
        do_acc(20'hFABCD, c, w, ea);
        check("R10 20b addr", ea, 20'hFABCD);
        check("R8 20b top", top_pins_addr, 1);
    endtask

    task automatic t_strap();
        check("R11 captured", bus_is_8bit, 1);
        byte_strap = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 held", bus_is_8bit, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_cs_basic();
        t_nowait();
        t_width();
        t_strap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule